// File: doc/BRIEF.md
# Per-Hart Wired Interrupt Delivery Controller

This block serves the wired delivery path of an interrupt domain. For every hart it looks at all sources that are both enabled and pending, keeps those whose target word names that hart and whose priority passes the hart's threshold, and picks a single winner. The winner is published as a "top" word and drives the hart's external interrupt line. Each hart also has a delivery-enable bit, a force bit that raises the line with nothing pending, and a priority threshold.

Software uses a small word-addressed register port. Per-source target words hold a hart index and a priority. Each hart has a 32-byte window with a plain top read and a claim read. A claim returns the same value as the top read, and it also emits a one-cycle clear pulse toward the pending store that sits outside this block. The pending store itself, the per-source enables and the input rectification are kept by neighbouring logic. They arrive here as vectors.

The winner is found by a binary comparison tree that is registered once. The top word therefore reflects the inputs seen at the previous clock edge. The interrupt line is registered once more behind it.

Top module: `hart_irq_deliver`

## Requirements
- R1: A source id (1..SRC_NUM; id 0 is never a candidate) is a candidate for hart h only when its bit in `enpend_i` is 1 and the hart index held in bits 31:18 of its target word equals h.
- R2: Among candidates the smallest priority number wins. Between equal priorities the smallest source id wins.
- R3: With a hart threshold of 0 every priority is eligible. With a nonzero threshold T, only priorities strictly less than T are eligible.
- R4: The top word has the winning id in bits 25:16, its priority in bits 7:0 and zeros elsewhere. It is 0 when there is no candidate. It reflects the inputs sampled at the previous clock edge.
- R5: A hart's `irq_o` bit is 1 one edge after `dom_en_i`, delivery enable and (force or nonzero top) all hold, and 0 otherwise.
- R6: A claim read returns the top word. In the same cycle that `reg_rdata_o` is valid, `pend_clr_o` carries a one-hot pulse at the winner's id (all zero when the top word was 0).
- R7: A claim leaves the winner's pending bit set (no clear pulse) when `level_i` of that id is 1 (level-sensitive) and `rin_i` of that id is 1 (rectified input active). An edge source, or a level source whose rectified input is 0, gets the clear pulse.
- R8: A claim read that finds a top word of 0 returns 0 and clears the hart's force bit.
- R9: A target write stores the priority as write bits 7:0 masked to PRIO_W bits, and a masked value of 0 is stored as 1. After reset every target holds hart 0 and priority 1.
- R10: Hart window offsets are 0x00 delivery enable, 0x04 force, 0x08 threshold, 0x18 top and 0x1C claim, at 0x4000 + 32*h. Delivery and force keep write bit 0 only. The threshold keeps the low PRIO_W bits.
- R11: Target word for id n sits at 0x3000 + 4*n and reads back as hart index in bits 31:18, priority in bits 7:0 and zeros elsewhere. Read data is valid in the cycle after `reg_rd_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dom_en_i | input | 1 | Domain-wide interrupt enable |
| enpend_i | input | SRC_NUM+1 | Enabled-and-pending bit per source id (bit 0 unused) |
| level_i | input | SRC_NUM+1 | 1 when the source is level-sensitive |
| rin_i | input | SRC_NUM+1 | Rectified (active-high) source input |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 16 | Byte address of the word access |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, one cycle after the strobe |
| pend_clr_o | output | SRC_NUM+1 | One-cycle pending-clear pulse from a claim |
| irq_o | output | NUM_HARTS | External interrupt line per hart |

## Verification
A wrong target priority, threshold or tree decision shows up at the ports as a wrong top word. The top word can be read in the third cycle after the input change, and the hart's line moves one edge after that. A stuck force or delivery bit shows on `irq_o` within two edges, and also in the readback of the window. A claim that clears the wrong source, or clears a live level source, is visible as a wrong `pend_clr_o` pattern in the same cycle as the claim data. The next top read then names a different winner.

// File: rtl/hid_pkg.sv
package hid_pkg;
  localparam int HIDX_W   = 14;
  localparam int HIDX_LSB = 18;
  localparam int TOPID_LSB = 16;

  // stored priority: masked raw field, zero promoted to one
  function automatic logic [7:0] prio_store(input logic [7:0] raw, input logic [7:0] mask);
    logic [7:0] m;
    m = raw & mask;
    return (m == 8'd0) ? 8'd1 : m;
  endfunction

  // threshold gate: zero lets all through, else strictly below
  function automatic logic prio_elig(input logic [7:0] p, input logic [7:0] thr);
    return (thr == 8'd0) || (p < thr);
  endfunction

  function automatic logic [31:0] top_word(input logic [9:0] id, input logic [7:0] p);
    return {6'd0, id, 8'd0, p};
  endfunction

  // claim keeps a level source pending while its input is active
  function automatic logic claim_keeps(input logic lvl, input logic rin);
    return lvl & rin;
  endfunction
endpackage

// File: rtl/hid_target_bank.sv
module hid_target_bank
  import hid_pkg::*;
#(
  parameter int SRC_NUM = 15,
  parameter int PRIO_W  = 3
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 wr_en_i,
  input  logic [$clog2(SRC_NUM+1)-1:0]         wr_id_i,
  input  logic [HIDX_W-1:0]                    wr_hidx_i,
  input  logic [7:0]                           wr_prio_i,
  output logic [SRC_NUM:0][HIDX_W-1:0]         hidx_o,
  output logic [SRC_NUM:0][PRIO_W-1:0]         prio_o
);
  localparam logic [7:0] MASK = 8'((1 << PRIO_W) - 1);
  logic [PRIO_W-1:0] new_prio;

  assign new_prio = PRIO_W'(prio_store(wr_prio_i, MASK));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i <= SRC_NUM; i++) begin
        hidx_o[i] <= '0;
        prio_o[i] <= PRIO_W'(1);
      end
    end else if (wr_en_i) begin
      for (int i = 1; i <= SRC_NUM; i++) begin
        if (32'(wr_id_i) == i) begin
          hidx_o[i] <= wr_hidx_i;
          prio_o[i] <= new_prio;
        end
      end
    end
  end

  generate
    for (genvar g = 1; g <= SRC_NUM; g++) begin : g_chk
      AST_PRIO_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        prio_o[g] != '0); // R9
    end
  endgenerate
endmodule

// File: rtl/hid_hart_pick.sv
module hid_hart_pick
  import hid_pkg::*;
#(
  parameter int SRC_NUM = 15,
  parameter int PRIO_W  = 3,
  parameter int HART_ID = 0
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [SRC_NUM:0]             enpend_i,
  input  logic [SRC_NUM:0][HIDX_W-1:0] hidx_i,
  input  logic [SRC_NUM:0][PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]            thr_i,
  output logic [31:0]                  top_o
);
  localparam int ID_W = $clog2(SRC_NUM + 1);
  localparam int LVS  = 1 << ID_W;

  logic [LVS-1:0]    leaf_v;
  logic [PRIO_W-1:0] leaf_p [LVS];
  logic              nv  [1:2*LVS-1];
  logic [ID_W-1:0]   nid [1:2*LVS-1];
  logic [PRIO_W-1:0] np  [1:2*LVS-1];
  logic              unused_zero;

  assign unused_zero = ^{enpend_i[0], hidx_i[0], prio_i[0]};

  generate
    for (genvar g = 0; g < LVS; g++) begin : g_leaf
      if (g >= 1 && g <= SRC_NUM) begin : g_real
        assign leaf_v[g] = enpend_i[g] && (hidx_i[g] == HIDX_W'(HART_ID)) &&
                           prio_elig(8'(prio_i[g]), 8'(thr_i));
        assign leaf_p[g] = prio_i[g];
      end else begin : g_pad
        assign leaf_v[g] = 1'b0;
        assign leaf_p[g] = '0;
      end
    end
  endgenerate

  // binary comparison tree: left subtree holds smaller ids, wins ties
  always_comb begin
    for (int i = 0; i < LVS; i++) begin
      nv[LVS+i]  = leaf_v[i];
      nid[LVS+i] = ID_W'(i);
      np[LVS+i]  = leaf_p[i];
    end
    for (int k = LVS - 1; k >= 1; k--) begin
      if (nv[2*k+1] && (!nv[2*k] || (np[2*k+1] < np[2*k]))) begin
        nid[k] = nid[2*k+1];
        np[k]  = np[2*k+1];
      end else begin
        nid[k] = nid[2*k];
        np[k]  = np[2*k];
      end
      nv[k] = nv[2*k] | nv[2*k+1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) top_o <= '0;
    else         top_o <= nv[1] ? top_word(10'(nid[1]), 8'(np[1])) : 32'd0;
  end

  AST_TOP_BELOW_THR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (top_o != 0 && $past(thr_i) != 0) |-> (top_o[7:0] < 8'($past(thr_i)))); // R3
  AST_TOP_WAS_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (top_o != 0) |-> (($past(enpend_i) >> top_o[TOPID_LSB +: ID_W]) & 1) != 0); // R1
  AST_TOP_PRIO_NZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (top_o != 0) |-> (top_o[7:0] != 8'd0)); // R9
endmodule

// File: rtl/hid_hart_regs.sv
module hid_hart_regs #(
  parameter int PRIO_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dom_en_i,
  input  logic              wr_dlv_i,
  input  logic              wr_frc_i,
  input  logic              wr_thr_i,
  input  logic              wbit_i,
  input  logic [PRIO_W-1:0] wthr_i,
  input  logic              claim_empty_i,
  input  logic [31:0]       top_i,
  output logic              dlv_o,
  output logic              frc_o,
  output logic [PRIO_W-1:0] thr_o,
  output logic              irq_o
);
  logic want_line;
  assign want_line = dom_en_i && dlv_o && (frc_o || (top_i != 32'd0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dlv_o <= 1'b0;
      frc_o <= 1'b0;
      thr_o <= '0;
      irq_o <= 1'b0;
    end else begin
      if (wr_dlv_i) dlv_o <= wbit_i;
      if (wr_frc_i) frc_o <= wbit_i;
      else if (claim_empty_i) frc_o <= 1'b0;
      if (wr_thr_i) thr_o <= wthr_i;
      irq_o <= want_line;
    end
  end

  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(dom_en_i && dlv_o)); // R5
  AST_FORCE_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_empty_i |=> !frc_o); // R8
endmodule

// File: rtl/hart_irq_deliver.sv
module hart_irq_deliver
  import hid_pkg::*;
#(
  parameter int SRC_NUM   = 15,
  parameter int NUM_HARTS = 4,
  parameter int PRIO_W    = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 dom_en_i,
  input  logic [SRC_NUM:0]     enpend_i,
  input  logic [SRC_NUM:0]     level_i,
  input  logic [SRC_NUM:0]     rin_i,
  input  logic                 reg_wr_i,
  input  logic                 reg_rd_i,
  input  logic [15:0]          reg_addr_i,
  input  logic [31:0]          reg_wdata_i,
  output logic [31:0]          reg_rdata_o,
  output logic [SRC_NUM:0]     pend_clr_o,
  output logic [NUM_HARTS-1:0] irq_o
);
  localparam int ID_W = $clog2(SRC_NUM + 1);
  localparam int HS_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;
  localparam logic [4:0] OFF_DLV = 5'h00, OFF_FRC = 5'h04, OFF_THR = 5'h08,
                         OFF_TOP = 5'h18, OFF_CLM = 5'h1C;

  // ---------------- decode ----------------
  logic [9:0]      tgt_idx;
  logic [6:0]      win_h;
  logic [4:0]      win_off;
  logic            tgt_ok, win_ok;
  logic [ID_W-1:0] tgt_id;
  logic [HS_W-1:0] hsel;
  logic            unused_bits;

  assign tgt_idx = reg_addr_i[11:2];
  assign win_h   = reg_addr_i[11:5];
  assign win_off = reg_addr_i[4:0];
  assign tgt_ok  = (reg_addr_i[15:12] == 4'h3) && (32'(tgt_idx) >= 1) &&
                   (32'(tgt_idx) <= SRC_NUM);
  assign win_ok  = (reg_addr_i[15:12] == 4'h4) && (32'(win_h) < NUM_HARTS);
  assign tgt_id  = ID_W'(tgt_idx);
  assign hsel    = HS_W'(win_h);
  assign unused_bits = ^{reg_addr_i[1:0], reg_wdata_i[17:8]};

  // ---------------- target words ----------------
  logic [SRC_NUM:0][HIDX_W-1:0] hidx_arr;
  logic [SRC_NUM:0][PRIO_W-1:0] prio_arr;

  hid_target_bank #(.SRC_NUM(SRC_NUM), .PRIO_W(PRIO_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (reg_wr_i && tgt_ok),
    .wr_id_i   (tgt_id),
    .wr_hidx_i (reg_wdata_i[HIDX_LSB +: HIDX_W]),
    .wr_prio_i (reg_wdata_i[7:0]),
    .hidx_o    (hidx_arr),
    .prio_o    (prio_arr)
  );

  // ---------------- per-hart pickers and registers ----------------
  logic [31:0]       top_arr [NUM_HARTS];
  logic [PRIO_W-1:0] thr_arr [NUM_HARTS];
  logic [NUM_HARTS-1:0] dlv_arr, frc_arr, claim_h;

  generate
    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
      logic sel;
      assign sel = win_ok && (32'(win_h) == h);
      assign claim_h[h] = reg_rd_i && sel && (win_off == OFF_CLM);

      hid_hart_pick #(.SRC_NUM(SRC_NUM), .PRIO_W(PRIO_W), .HART_ID(h)) u_pick (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .enpend_i (enpend_i),
        .hidx_i   (hidx_arr),
        .prio_i   (prio_arr),
        .thr_i    (thr_arr[h]),
        .top_o    (top_arr[h])
      );

      hid_hart_regs #(.PRIO_W(PRIO_W)) u_regs (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .dom_en_i      (dom_en_i),
        .wr_dlv_i      (reg_wr_i && sel && (win_off == OFF_DLV)),
        .wr_frc_i      (reg_wr_i && sel && (win_off == OFF_FRC)),
        .wr_thr_i      (reg_wr_i && sel && (win_off == OFF_THR)),
        .wbit_i        (reg_wdata_i[0]),
        .wthr_i        (reg_wdata_i[PRIO_W-1:0]),
        .claim_empty_i (claim_h[h] && (top_arr[h] == 32'd0)),
        .top_i         (top_arr[h]),
        .dlv_o         (dlv_arr[h]),
        .frc_o         (frc_arr[h]),
        .thr_o         (thr_arr[h]),
        .irq_o         (irq_o[h])
      );
    end
  endgenerate

  // ---------------- read path and claim ----------------
  logic [31:0]     rd_val, sel_top;
  logic [ID_W-1:0] win_id;

  assign sel_top = win_ok ? top_arr[hsel] : 32'd0;
  assign win_id  = sel_top[TOPID_LSB +: ID_W];

  always_comb begin
    rd_val = 32'd0;
    if (tgt_ok) begin
      rd_val = {hidx_arr[tgt_id], 10'd0, 8'(prio_arr[tgt_id])};
    end else if (win_ok) begin
      case (win_off)
        OFF_DLV:          rd_val = {31'd0, dlv_arr[hsel]};
        OFF_FRC:          rd_val = {31'd0, frc_arr[hsel]};
        OFF_THR:          rd_val = 32'(thr_arr[hsel]);
        OFF_TOP, OFF_CLM: rd_val = sel_top;
        default:          rd_val = 32'd0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_rdata_o <= '0;
      pend_clr_o  <= '0;
    end else begin
      reg_rdata_o <= reg_rd_i ? rd_val : 32'd0;
      pend_clr_o  <= '0;
      if ((|claim_h) && (sel_top != 32'd0) &&
          !claim_keeps(level_i[win_id], rin_i[win_id]))
        pend_clr_o[win_id] <= 1'b1;
    end
  end

  AST_CLR_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pend_clr_o)); // R6
  AST_CLR_FROM_CLAIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_clr_o != '0) |-> $past(reg_rd_i)); // R6
  AST_LEVEL_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_clr_o & $past(level_i & rin_i)) == '0); // R7
endmodule

// File: tb/hart_irq_deliver_tb.sv
`timescale 1ns/1ps
module hart_irq_deliver_tb;
  localparam int SRC_NUM = 15;
  localparam int NUM_HARTS = 4;
  localparam int PRIO_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dom_en = 1'b0;
  logic [SRC_NUM:0] enpend = '0, level = '0, rin = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [SRC_NUM:0] pend_clr;
  logic [NUM_HARTS-1:0] irq;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  hart_irq_deliver #(.SRC_NUM(SRC_NUM), .NUM_HARTS(NUM_HARTS), .PRIO_W(PRIO_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .dom_en_i(dom_en), .enpend_i(enpend),
    .level_i(level), .rin_i(rin), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .pend_clr_o(pend_clr), .irq_o(irq)
  );

  // {pending[15:0], hart0 threshold[7:0], expected hart0 top[31:0]}
  localparam logic [55:0] TBL [10] = '{
    {16'h000E, 8'd0, 32'h0002_0003},  // R2 tie 2 vs 3
    {16'h000E, 8'd3, 32'h0000_0000},  // R3 none below 3
    {16'h000E, 8'd4, 32'h0002_0003},  // R3
    {16'h0042, 8'd0, 32'h0001_0005},  // R2
    {16'h0010, 8'd0, 32'h0000_0000},  // R1 other hart
    {16'h0050, 8'd0, 32'h0006_0007},  // R1
    {16'h0024, 8'd0, 32'h0005_0001},  // R9 zero prio stored as 1
    {16'h0048, 8'd6, 32'h0003_0003},  // R3
    {16'h0040, 8'd7, 32'h0000_0000},  // R3 equal to threshold
    {16'h0000, 8'd0, 32'h0000_0000}   // R4 empty
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [15:0] a, output logic [31:0] d, output logic [SRC_NUM:0] c);
    @(negedge clk);
    reg_rd = 1'b1; addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = rdata;
    c = pend_clr;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    logic [SRC_NUM:0] c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    check("R5 irq after reset", 32'(irq), 32'd0);
    check("R6 clear after reset", 32'(pend_clr), 32'd0);
    do_rd(16'h3024, d, c); check("R9 target reset value", d, 32'h0000_0001);
    do_rd(16'h4000, d, c); check("R10 delivery reset", d, 32'd0);

    // targets: id1 p5, id2 p3, id3 p3, id4 hart1 p2, id5 p0(->1), id6 p7
    do_wr(16'h3004, 32'h0000_0005);
    do_wr(16'h3008, 32'h0000_0003);
    do_wr(16'h300C, 32'h0000_0003);
    do_wr(16'h3010, 32'h0004_0002);
    do_wr(16'h3014, 32'h0000_0008);
    do_wr(16'h3018, 32'h0000_0007);
    do_rd(16'h3010, d, c); check("R11 target readback", d, 32'h0004_0002);
    do_rd(16'h3014, d, c); check("R9 zero priority stored as 1", d, 32'h0000_0001);

    // register masks
    do_wr(16'h4000, 32'h0000_0003);
    do_rd(16'h4000, d, c); check("R10 delivery keeps bit0", d, 32'd1);
    do_wr(16'h4004, 32'hFFFF_FFFE);
    do_rd(16'h4004, d, c); check("R10 force keeps bit0", d, 32'd0);
    do_wr(16'h4008, 32'h0000_00FD);
    do_rd(16'h4008, d, c); check("R10 threshold masked", d, 32'd5);
    dom_en = 1'b1;

    // table walk
    for (int i = 0; i < 10; i++) begin
      enpend = TBL[i][55:40];
      do_wr(16'h4008, 32'(TBL[i][39:32]));
      settle();
      do_rd(16'h4018, d, c);
      check($sformatf("R4 top vec %0d", i), d, TBL[i][31:0]);
      check($sformatf("R5 line vec %0d", i), 32'(irq[0]), 32'(TBL[i][31:0] != 0));
    end

    // other hart
    enpend = 16'h0010; settle();
    do_rd(16'h4038, d, c); check("R1 hart1 top", d, 32'h0004_0002);

    // claim of an edge source
    do_wr(16'h4008, 32'd0);
    enpend = 16'h0044; settle();
    do_rd(16'h401C, d, c);
    check("R6 claim data", d, 32'h0002_0003);
    check("R6 claim clear pulse", 32'(c), 32'h0000_0004);
    enpend = enpend & ~c; settle();
    do_rd(16'h4018, d, c); check("R6 next winner", d, 32'h0006_0007);

    // level source with active input stays pending
    enpend = 16'h0044; level = 16'h0004; rin = 16'h0004; settle();
    do_rd(16'h401C, d, c);
    check("R7 level claim data", d, 32'h0002_0003);
    check("R7 level active no clear", 32'(c), 32'd0);
    rin = 16'h0000; settle();
    do_rd(16'h401C, d, c);
    check("R7 level inactive clears", 32'(c), 32'h0000_0004);
    level = '0;

    // force and empty claim
    enpend = '0;
    do_wr(16'h4004, 32'd1); settle();
    check("R5 force raises line", 32'(irq[0]), 32'd1);
    do_rd(16'h401C, d, c);
    check("R8 empty claim returns 0", d, 32'd0);
    settle();
    do_rd(16'h4004, d, c); check("R8 force cleared", d, 32'd0);
    check("R8 line dropped", 32'(irq[0]), 32'd0);

    // gating
    enpend = 16'h0004; dom_en = 1'b0; settle();
    check("R5 domain disable", 32'(irq[0]), 32'd0);
    dom_en = 1'b1; settle();
    check("R5 domain enable", 32'(irq[0]), 32'd1);
    do_wr(16'h4000, 32'd0); settle();
    check("R5 delivery off", 32'(irq[0]), 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule